// File: doc/BRIEF.md
# Event Status Register with Edge Qualification

This block forms one tier of a layered instrument status tree. Every clock it samples a live vector of condition flags. For each flag, two separate masks choose which edges count: one mask is for a low-to-high change and the other is for a high-to-low change. A qualifying edge sets a sticky event bit. The event bits stay set until a host reads them, and that read clears them.

A third mask, the enable mask, gates the event bits. The gated bits are ORed together into a single summary output. That summary is meant to drive one condition input of the next tier up, so several instances can be chained into a tree.

A small register port gives the host access to the block. The host can read and write the two edge masks and the enable mask. It can read the live condition vector and the latched events. The parameter `W` sets the width of every vector.

Top module: `evt_status_level`

## Requirements
- R1: When condition bit i changes from 0 to 1 between two consecutive clock samples, event bit i is set at that clock edge only if rising-mask bit i is 1.
- R2: When condition bit i changes from 1 to 0 between two consecutive clock samples, event bit i is set at that clock edge only if falling-mask bit i is 1.
- R3: The rising mask (address 1) and the falling mask (address 2) are written when `wr_en` is high and read back unchanged, and reading them does not alter them.
- R4: A read of address 3 returns the event bits as they were before the read, and clears them at the same clock edge.
- R5: If a read of address 3 and a qualifying edge on bit i fall in the same cycle, event bit i is set after that edge.
- R6: `summary_o` equals the OR over i of (event bit i AND enable bit i). It follows the registers combinationally, in the same cycle that either register changes.
- R7: The enable mask (address 4) is read/write and is not cleared by reading.
- R8: Address 0 returns the live `cond_i` value. Writes to address 0 and to address 3 have no effect.
- R9: After reset, the event bits, the falling mask, the enable mask and the previous condition sample are all zero, and the rising mask is all ones.
- R10: Event bits that are set stay set while no read of address 3 occurs, whatever the condition inputs do.
- R11: Addresses 5 to 7 read as zero and ignore writes. `rdata_o` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cond_i | input | W | Live condition flags, sampled every clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 3 clears the events |
| addr | input | 3 | Register address: 0 condition, 1 rising mask, 2 falling mask, 3 events, 4 enable |
| wdata | input | W | Write data |
| rdata_o | output | W | Combinational read data, valid while `rd_en` is high |
| summary_o | output | 1 | OR of the enabled event bits, fed to the next tier's condition input |

## Verification
Two operations can land on the same clock edge: the host's clearing read of the event register, and a qualifying edge on a condition bit. The bench forces this overlap in two ways. It runs a directed cycle that reads address 3 while a masked rising edge arrives. It also runs a long stretch of random cycles in which reads, writes and condition changes overlap freely. A behavioural model computes the expected results. In that model the clear is applied first and the new edges are ORed in afterwards. Every cycle, `rdata_o` and `summary_o` are compared against the model. A colliding bit must therefore read back as set on the following read, while every other bit reads as cleared.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COND = 3'd0,
    ADDR_RISE = 3'd1,
    ADDR_FALL = 3'd2,
    ADDR_EVT  = 3'd3,
    ADDR_ENA  = 3'd4
  } esr_addr_e;
endpackage

// File: rtl/esr_rst_sync.sv
module esr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/esr_mask_bank.sv
module esr_mask_bank
  import esr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rise_msk_o,
  output logic [W-1:0]      fall_msk_o,
  output logic [W-1:0]      ena_msk_o
);
  logic [W-1:0] rise_q, fall_q, ena_q;
  logic [W-1:0] rise_d, fall_d, ena_d;
  logic         rise_we, fall_we, ena_we;

  always_comb begin
    rise_we = wr_en && (addr == ADDR_RISE);
    fall_we = wr_en && (addr == ADDR_FALL);
    ena_we  = wr_en && (addr == ADDR_ENA);
    rise_d  = rise_we ? wdata : rise_q;
    fall_d  = fall_we ? wdata : fall_q;
    ena_d   = ena_we  ? wdata : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '1;
      fall_q <= '0;
      ena_q  <= '0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      ena_q  <= ena_d;
    end
  end

  assign rise_msk_o = rise_q;
  assign fall_msk_o = fall_q;
  assign ena_msk_o  = ena_q;
endmodule

// File: rtl/esr_edge_qual.sv
module esr_edge_qual #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] rise_msk,
  input  logic [W-1:0] fall_msk,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cond_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic went_up, went_down;
    assign went_up   = cond_i[i] & ~prev_q[i];
    assign went_down = ~cond_i[i] & prev_q[i];
    assign hit_o[i]  = (went_up & rise_msk[i]) | (went_down & fall_msk[i]);
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/esr_event_latch.sv
module esr_event_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic         clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] evt_q, evt_d;

  always_comb begin
    evt_d = (clr_i ? '0 : evt_q) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/evt_status_level.sv
module evt_status_level
  import esr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      cond_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata_o,
  output logic              summary_o
);
  logic         rst_sync_n;
  logic [W-1:0] rise_msk, fall_msk, ena_msk;
  logic [W-1:0] prev_cond, hit, evt;
  logic         evt_clr;

  esr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  esr_mask_bank #(.W(W)) u_masks (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rise_msk_o (rise_msk),
    .fall_msk_o (fall_msk),
    .ena_msk_o  (ena_msk)
  );

  esr_edge_qual #(.W(W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cond_i   (cond_i),
    .rise_msk (rise_msk),
    .fall_msk (fall_msk),
    .prev_o   (prev_cond),
    .hit_o    (hit)
  );

  assign evt_clr = rd_en && (addr == ADDR_EVT);

  esr_event_latch #(.W(W)) u_evt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hit_i (hit),
    .clr_i (evt_clr),
    .evt_o (evt)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (addr)
        ADDR_COND: rdata_o = cond_i;
        ADDR_RISE: rdata_o = rise_msk;
        ADDR_FALL: rdata_o = fall_msk;
        ADDR_EVT:  rdata_o = evt;
        ADDR_ENA:  rdata_o = ena_msk;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign summary_o = |(evt & ena_msk);
endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cond_i,
  input logic [W-1:0] prev_cond,
  input logic [W-1:0] rise_msk,
  input logic [W-1:0] fall_msk,
  input logic [W-1:0] evt,
  input logic         rd_en,
  input logic [2:0]   addr
);
  logic         armed_q;
  logic [W-1:0] rise_hit, fall_hit;
  logic         rd_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign rise_hit = cond_i & ~prev_cond & rise_msk;
  assign fall_hit = ~cond_i & prev_cond & fall_msk;
  assign rd_evt   = rd_en && (addr == 3'd3);

  // R1 and R5: a masked rising edge leaves its event bit set, even during a clearing read
  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rise_hit != '0) |=> ((evt & $past(rise_hit)) == $past(rise_hit)));

  // R2: a masked falling edge leaves its event bit set
  a_r2_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && fall_hit != '0) |=> ((evt & $past(fall_hit)) == $past(fall_hit)));

  // R10: without a read of the event register, no set bit is lost
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !rd_evt) |=> ((evt & $past(evt)) == $past(evt)));

  // R4: a clearing read with no qualifying edge empties the event register
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rd_evt && (rise_hit | fall_hit) == '0) |=> (evt == '0));

  // R1 and R2: new event bits appear only where an edge was qualified
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((evt & ~$past(evt) & ~($past(rise_hit) | $past(fall_hit))) == '0));
endmodule

bind evt_status_level esr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cond_i    (cond_i),
  .prev_cond (prev_cond),
  .rise_msk  (rise_msk),
  .fall_msk  (fall_msk),
  .evt       (evt),
  .rd_en     (rd_en),
  .addr      (addr)
);

// File: tb/test_evt_status_level.sv
module test_evt_status_level;
  localparam int W       = 8;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cond_i;
  logic         wr_en, rd_en;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata_o;
  logic         summary_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  logic [W-1:0] m_rise, m_fall, m_ena, m_evt, m_prev;

  always #(CLK_PER/2) clk = ~clk;

  evt_status_level #(.W(W)) i_evt_status_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata_o   (rdata_o),
    .summary_o (summary_o)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare, then advance the model at the rising edge
  task automatic cyc(input bit wr, input bit rd, input logic [2:0] a,
                     input logic [W-1:0] d, input logic [W-1:0] c, input string tag);
    logic [W-1:0] exp_rd, hit;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d; cond_i = c;
    #1;
    exp_rd = '0;
    if (rd) begin
      case (a)
        3'd0: exp_rd = c;
        3'd1: exp_rd = m_rise;
        3'd2: exp_rd = m_fall;
        3'd3: exp_rd = m_evt;
        3'd4: exp_rd = m_ena;
        default: exp_rd = '0;
      endcase
    end
    check(tag, rdata_o, exp_rd, "rdata");
    check(tag, {{(W-1){1'b0}}, summary_o}, {{(W-1){1'b0}}, (m_evt & m_ena) != '0}, "summary");
    @(posedge clk);
    hit = (c & ~m_prev & m_rise) | (~c & m_prev & m_fall);
    m_evt = ((rd && a == 3'd3) ? '0 : m_evt) | hit;
    m_prev = c;
    if (wr) begin
      if (a == 3'd1) m_rise = d;
      if (a == 3'd2) m_fall = d;
      if (a == 3'd4) m_ena  = d;
    end
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cond_i = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    m_rise = '1; m_fall = '0; m_ena = '0; m_evt = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9 reset values, R11 unmapped and idle read data
    cyc(0, 1, 3'd1, '0, '0, "R9");
    cyc(0, 1, 3'd2, '0, '0, "R9");
    cyc(0, 1, 3'd3, '0, '0, "R9");
    cyc(0, 1, 3'd4, '0, '0, "R9");
    cyc(0, 1, 3'd5, '0, '0, "R11");
    cyc(1, 0, 3'd6, 8'hFF, '0, "R11");
    cyc(0, 0, 3'd1, '0, '0, "R11");

    // R3 and R7: program the masks and read them back twice
    cyc(1, 0, 3'd1, 8'h0F, '0, "R3");
    cyc(1, 0, 3'd2, 8'hF0, '0, "R3");
    cyc(1, 0, 3'd4, 8'h80, '0, "R7");
    cyc(0, 1, 3'd1, '0, '0, "R3");
    cyc(0, 1, 3'd1, '0, '0, "R3");
    cyc(0, 1, 3'd2, '0, '0, "R3");
    cyc(0, 1, 3'd4, '0, '0, "R7");
    cyc(0, 1, 3'd4, '0, '0, "R7");

    // R1: all bits rise, only the rising-mask bits latch
    cyc(0, 0, 3'd0, '0, 8'hFF, "R1");
    cyc(0, 1, 3'd0, '0, 8'hFF, "R8");
    cyc(0, 1, 3'd3, '0, 8'hFF, "R4");
    cyc(0, 1, 3'd3, '0, 8'hFF, "R4");
    // R2 and R6: falling edges latch the upper half, enable bit 7 raises the summary
    cyc(0, 0, 3'd0, '0, 8'h00, "R2");
    cyc(0, 0, 3'd0, '0, 8'h00, "R6");
    cyc(0, 0, 3'd0, '0, 8'h00, "R10");
    cyc(1, 0, 3'd4, 8'h00, 8'h00, "R6");
    cyc(0, 1, 3'd3, '0, 8'h00, "R6");

    // R5: clearing read collides with a rising edge on bit 0
    cyc(0, 0, 3'd0, '0, 8'h02, "R5");
    cyc(0, 1, 3'd3, '0, 8'h03, "R5");
    cyc(0, 1, 3'd3, '0, 8'h03, "R5");

    // R8: writes to the condition and event addresses change nothing
    cyc(1, 0, 3'd0, 8'hAA, 8'h03, "R8");
    cyc(1, 0, 3'd3, 8'hFF, 8'h03, "R8");
    cyc(0, 1, 3'd3, '0, 8'h03, "R8");
    cyc(0, 1, 3'd0, '0, 8'h5C, "R8");

    // R10 with R1, R2, R5 and R6 mixed: random traffic against the model
    for (int k = 0; k < 2000; k++) begin
      logic [2:0] a;
      bit wr, rd;
      a  = 3'($urandom_range(0, 5));
      wr = ($urandom_range(0, 3) == 0);
      rd = ($urandom_range(0, 2) == 0);
      cyc(wr, rd, a, W'($urandom), W'($urandom), "R10");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule